// File: doc/BRIEF.md
# DAC Start Synchronizer

This block governs the start-up of one stereo DAC channel. It watches the channel's enable bit, the shared frame-sync strobe and the free-running conversion clock. From these it decides when the serial interface may ask for samples and when the converter actually begins. Sample requests resume at the first frame boundary after the enable is set. Conversion is held off until six frame boundaries have passed, which gives a four-word stereo input buffer time to fill. Conversion then starts on the next conversion-clock rising edge.

Both frame sync and conversion clock come from outside the system clock domain. Each passes through a synchronizer and an edge detector before the sequencer sees it. The count is in whole frames and the final alignment is to the conversion clock. As a result, any number of channels that share one frame sync and are enabled within the same frame begin converting on the same conversion-clock edge. Clearing the enable stops requests and conversion in the same cycle and puts the block back at its starting point.

Top module: `dac_start_sync`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both `smp_req_o` and `conv_act_o` are 0.
- R2: After `chan_en_i` rises, `smp_req_o` stays 0 until the first frame-sync rising edge seen after the enable. An input edge is seen two system clocks after it is sampled (two synchronizer stages). The request is never raised in the frame in which the enable arrives.
- R3: From that first seen frame-sync edge onward, `smp_req_o` is 1 in every cycle in which `chan_en_i` stays 1.
- R4: `conv_act_o` stays 0 until at least six seen frame-sync rising edges have occurred after the enable.
- R5: `conv_act_o` goes to 1 one cycle after the first seen conversion-clock rising edge that occurs strictly after the sixth seen frame-sync edge. A conversion-clock edge seen in the same cycle as the sixth frame edge does not start conversion.
- R6: When `chan_en_i` is 0, both outputs are 0 in that same cycle, and the sequencer is back in its idle state at the next clock.
- R7: If the enable is cleared and set again before conversion has started, the frame count restarts from zero. At least six new frame edges are needed again.
- R8: Two instances that share frame sync and conversion clock, and whose enables rise between the same pair of seen frame-sync edges, raise `conv_act_o` in the same cycle.
- R9: Once `conv_act_o` is 1, it stays 1 for as long as `chan_en_i` stays 1, whatever frame sync and conversion clock do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en_i | input | 1 | Channel enable bit from the control register |
| fsync_i | input | 1 | Frame-sync strobe, asynchronous to clk |
| cclk_i | input | 1 | Conversion clock, asynchronous to clk |
| smp_req_o | output | 1 | Sample requests are permitted in the current frame |
| conv_act_o | output | 1 | Conversions are running |

## Verification
The case that is hardest to reach from the ports is an enable that drops for only a cycle or two partway through the six-frame count, followed by a check that the count truly restarted. A second hard case is a conversion-clock edge that lands in the very cycle the sixth frame edge is seen. The stimulus drives randomly sized frame and conversion-clock periods with random enable windows, some of them one or two cycles long. It also includes a directed glitch in the middle of the count. A second instance is enabled a few cycles after the first within the same frame, and both start-up edges are compared.

// File: rtl/dss_pkg.sv
package dss_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_FS   = 2'd1,
    ST_WAIT_CONV = 2'd2,
    ST_RUN       = 2'd3
  } dss_state_e;

  // Next-state rule of the start sequencer.
  function automatic dss_state_e dss_next(input dss_state_e cur, input logic en,
                                          input logic fs_rise, input logic conv_rise,
                                          input logic last_frame);
    dss_state_e nxt;
    nxt = cur;
    if (!en) begin
      nxt = ST_IDLE;
    end else begin
      unique case (cur)
        ST_IDLE:      nxt = ST_WAIT_FS;
        ST_WAIT_FS:   if (fs_rise && last_frame) nxt = ST_WAIT_CONV;
        ST_WAIT_CONV: if (conv_rise) nxt = ST_RUN;
        ST_RUN:       nxt = ST_RUN;
        default:      nxt = ST_IDLE;
      endcase
    end
    return nxt;
  endfunction

  // Requests are allowed once at least one frame edge has been counted.
  function automatic logic dss_req(input dss_state_e cur, input logic en,
                                   input logic cnt_nz);
    return en && ((cur == ST_WAIT_FS && cnt_nz) || cur == ST_WAIT_CONV || cur == ST_RUN);
  endfunction

  function automatic logic dss_act(input dss_state_e cur, input logic en);
    return en && (cur == ST_RUN);
  endfunction

endpackage

// File: rtl/dss_edge_sync.sv
module dss_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign level_o = chain[STAGES-1];
  assign rise_o  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/dss_frame_counter.sv
module dss_frame_counter #(
  parameter int LIMIT = 6,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o,
  output logic          nz_o
);
  localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
  localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)                          cnt_o <= '0;
    else if (clr_i)                      cnt_o <= '0;
    else if (inc_i && cnt_o != LIM_V)    cnt_o <= cnt_o + 1'b1;
  end

  assign last_o = (cnt_o == LAST_V);
  assign nz_o   = (cnt_o != '0);
endmodule

// File: rtl/dss_start_fsm.sv
module dss_start_fsm
  import dss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       fs_rise_i,
  input  logic       conv_rise_i,
  input  logic       last_frame_i,
  output dss_state_e state_o
);
  dss_state_e nxt;

  always_comb nxt = dss_next(state_o, en_i, fs_rise_i, conv_rise_i, last_frame_i);

  always_ff @(posedge clk) begin
    if (!rst_n) state_o <= ST_IDLE;
    else        state_o <= nxt;
  end
endmodule

// File: rtl/dac_start_sync.sv
module dac_start_sync
  import dss_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FS_COUNT    = 6,
  localparam int CNT_W      = $clog2(FS_COUNT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en_i,
  input  logic fsync_i,
  input  logic cclk_i,
  output logic smp_req_o,
  output logic conv_act_o
);
  logic             fs_level, fs_rise;
  logic             cv_level, conv_rise;
  logic [CNT_W-1:0] fs_cnt;
  logic             last_frame, cnt_nz;
  logic             cnt_clr, cnt_inc;
  dss_state_e       state;

  dss_edge_sync #(.STAGES(SYNC_STAGES)) u_fs_sync (
    .clk(clk), .rst_n(rst_n), .d_i(fsync_i), .level_o(fs_level), .rise_o(fs_rise)
  );

  dss_edge_sync #(.STAGES(SYNC_STAGES)) u_cv_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cclk_i), .level_o(cv_level), .rise_o(conv_rise)
  );

  assign cnt_clr = (state == ST_IDLE);
  assign cnt_inc = chan_en_i && fs_rise && (state == ST_WAIT_FS);

  dss_frame_counter #(.LIMIT(FS_COUNT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(cnt_inc),
    .cnt_o(fs_cnt), .last_o(last_frame), .nz_o(cnt_nz)
  );

  dss_start_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en_i(chan_en_i), .fs_rise_i(fs_rise),
    .conv_rise_i(conv_rise), .last_frame_i(last_frame), .state_o(state)
  );

  assign smp_req_o  = dss_req(state, chan_en_i, cnt_nz);
  assign conv_act_o = dss_act(state, chan_en_i);
endmodule

// File: rtl/dss_chk.sv
module dss_chk
  import dss_pkg::*;
#(
  parameter int FS_COUNT = 6,
  parameter int CNT_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chan_en_i,
  input logic             smp_req_o,
  input logic             conv_act_o,
  input logic             fs_rise,
  input logic             conv_rise,
  input logic [CNT_W-1:0] fs_cnt,
  input dss_state_e       state
);
  // R2
  req_rise_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_req_o) |-> $past(fs_rise));

  // R4
  wait_conv_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_CONV) |-> (fs_cnt == CNT_W'(FS_COUNT)));

  // R5
  start_on_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_act_o) |-> ($past(conv_rise) && $past(state) == ST_WAIT_CONV));

  // R6
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en_i |=> (state == ST_IDLE));

  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_IDLE && state == ST_WAIT_FS) |-> (fs_cnt == '0));

  // R9
  run_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && chan_en_i) |=> (state == ST_RUN));
endmodule

bind dac_start_sync dss_chk #(.FS_COUNT(FS_COUNT), .CNT_W(CNT_W)) u_dss_chk (
  .clk(clk), .rst_n(rst_n), .chan_en_i(chan_en_i), .smp_req_o(smp_req_o),
  .conv_act_o(conv_act_o), .fs_rise(fs_rise), .conv_rise(conv_rise),
  .fs_cnt(fs_cnt), .state(state)
);

// File: tb/tb_dac_start_sync.sv
`timescale 1ns/1ps
module tb_dac_start_sync;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, en_b = 1'b0;
  logic fs = 1'b0, cv = 1'b0;
  logic req, act, req_b, act_b;

  int vectors = 0, fails = 0;
  int fs_per = 16, cv_per = 5;
  int fs_ph = 0, cv_ph = 0;
  logic gen_on = 1'b0;
  logic r7_win = 1'b0;
  logic r8_win = 1'b0;

  always #4 clk = ~clk;

  dac_start_sync dut (.clk(clk), .rst_n(rst_n), .chan_en_i(en), .fsync_i(fs),
                      .cclk_i(cv), .smp_req_o(req), .conv_act_o(act));
  dac_start_sync dut_b (.clk(clk), .rst_n(rst_n), .chan_en_i(en_b), .fsync_i(fs),
                        .cclk_i(cv), .smp_req_o(req_b), .conv_act_o(act_b));

  // Reference model, written from the requirements.
  logic fd1, fd2, fd3, cd1, cd2, cd3;
  int   m_frames;
  logic m_on, m_run, m_run_prev;

  function automatic logic want_req(logic e, logic on, int frames);
    return e && on && frames >= 1;
  endfunction
  function automatic logic want_act(logic e, logic run);
    return e && run;
  endfunction

  always @(posedge clk) begin
    logic frise, crise;
    frise = fd2 && !fd3;
    crise = cd2 && !cd3;
    m_run_prev = m_run;
    if (!rst_n) begin
      fd1 = 0; fd2 = 0; fd3 = 0; cd1 = 0; cd2 = 0; cd3 = 0;
      m_frames = 0; m_on = 0; m_run = 0;
    end else begin
      if (!en) begin
        m_on = 0; m_frames = 0; m_run = 0;
      end else if (!m_on) begin
        m_on = 1; m_frames = 0;
      end else begin
        if (!m_run && m_frames >= 6 && crise) m_run = 1;
        if (frise && m_frames < 6) m_frames++;
      end
      fd3 = fd2; fd2 = fd1; fd1 = fs;
      cd3 = cd2; cd2 = cd1; cd1 = cv;
    end
  end

  // Input waveform generator, driven away from the active edge.
  always @(negedge clk) begin
    if (gen_on) begin
      fs_ph = (fs_ph + 1) % fs_per;
      cv_ph = (cv_ph + 1) % cv_per;
      fs <= (fs_ph < 2);
      cv <= (cv_ph < (cv_per + 1) / 2);
    end
  end

  // Checks, sampled 3 ns after each rising edge.
  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      logic er, ea;
      er = want_req(en, m_on, m_frames);
      ea = want_act(en, m_run);
      vectors++;
      if (req !== er) begin
        fails++;
        if (!en) $display("FAIL R6 req: actual %0b expected %0b", req, er);
        else     $display("FAIL R2/R3 req: actual %0b expected %0b", req, er);
      end
      vectors++;
      if (act !== ea) begin
        fails++;
        if (!en)                    $display("FAIL R6 act: actual %0b expected %0b", act, ea);
        else if (r7_win)            $display("FAIL R7 act: actual %0b expected %0b", act, ea);
        else if (m_run && m_run_prev) $display("FAIL R9 act: actual %0b expected %0b", act, ea);
        else if (ea)                $display("FAIL R5 act: actual %0b expected %0b", act, ea);
        else                        $display("FAIL R4 act: actual %0b expected %0b", act, ea);
      end
      if (r8_win) begin
        vectors++;
        if (act_b !== act) begin
          fails++;
          $display("FAIL R8 second instance act: actual %0b expected %0b", act_b, act);
        end
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic wait_fs_input_rise();
    @(posedge fs);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1843));
    repeat (3) @(negedge clk);
    // R1: reset state
    vectors++;
    if (req !== 1'b0 || act !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: actual %0b%0b expected 00", req, act);
    end
    @(negedge clk);
    rst_n = 1'b1;
    gen_on = 1'b1;
    repeat (40) @(negedge clk);

    // Directed: R7 glitch mid-count, then full start.
    wait_fs_input_rise();
    repeat (4) @(negedge clk);
    en = 1'b1;
    repeat (3 * fs_per) @(negedge clk);
    r7_win = 1'b1;
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    repeat (5 * fs_per) @(negedge clk);
    r7_win = 1'b0;
    repeat (4 * fs_per) @(negedge clk);
    en = 1'b0;
    repeat (10) @(negedge clk);

    // Directed: R8 two instances enabled in the same frame.
    for (int k = 0; k < 4; k++) begin
      fs_per = 20 + 4 * k;
      cv_per = 3 + k;
      wait_fs_input_rise();
      repeat (4) @(negedge clk);
      en = 1'b1;
      repeat (2 + k) @(negedge clk);
      en_b = 1'b1;
      r8_win = 1'b1;
      repeat (9 * fs_per) @(negedge clk);
      r8_win = 1'b0;
      en = 1'b0; en_b = 1'b0;
      repeat (6) @(negedge clk);
    end

    // Random episodes, including one- and two-cycle enable windows.
    for (int ep = 0; ep < 60; ep++) begin
      fs_per = 8 + int'($urandom_range(0, 16));
      cv_per = 2 + int'($urandom_range(0, 6));
      en = 1'b1;
      if (($urandom % 4) == 0) repeat (1 + $urandom_range(0, 1)) @(negedge clk);
      else                     repeat (20 + $urandom_range(0, 180)) @(negedge clk);
      en = 1'b0;
      repeat (1 + $urandom_range(0, 20)) @(negedge clk);
    end
    summary();
  end
endmodule